// File: doc/BRIEF.md
# Watchdog Timer with Posted Cross-Domain Writes

The block is a watchdog peripheral split across two clocks. Software reads and writes its registers through a simple word-addressed port in the fast bus clock domain. The counter lives in a slow functional clock domain. It is an up-counter that starts from a programmable reload value, with an optional power-of-two prescaler. If software fails to service the timer before the counter passes its all-ones value, the block raises a reset request for the system.

Every write to a register that the counter domain uses is posted. The bus side keeps the value in a shadow, sets a per-register pending flag and toggles a request line. The counter domain synchronises the toggle, applies the value and returns an acknowledge toggle, which clears the flag once it arrives back on the bus side. While a flag is set, further writes to that register are dropped.

Starting and stopping the timer each take a fixed two-word sequence. Servicing the timer means writing a trigger value that differs from the previous one.

Top module: `wdog_posted`

## Requirements
- R1: After reset, the block holds the following state: every pending flag is clear, the configuration bit, control fields, load value and trigger value all read 0, the timer is stopped, and `reset_req` is low.
- R2: Word address 0 reads the revision constant `REV_ID` in bits 7:0 and zeros above. Writes to address 0 have no effect.
- R3: Address 1 holds a single configuration bit in bit 0 that is stored and reads back. It drives `autogate_en` directly, and bits above 0 read 0.
- R4: The status register at address 2 has one pending flag per posted register: bit 0 for control (address 3), bit 2 for load (address 4), bit 3 for trigger (address 5) and bit 4 for start/stop (address 6). An accepted write sets its flag in the next bus cycle. The flag clears without further action once the value has been applied in the counter domain.
- R5: A write to a posted register while that register's pending flag is set is dropped. The register keeps and reads back the earlier value.
- R6: The timer starts only when the start/stop register receives 0xBBBB and then 0x4444 as two consecutive applied words. Any other word in between cancels the sequence.
- R7: The timer stops only when the start/stop register receives 0xAAAA and then 0x5555 as two consecutive applied words. An intervening word cancels the sequence and the timer keeps running.
- R8: While running, the counter counts up one step per tick. A tick taken at all-ones produces a `reset_req` pulse one functional cycle wide and reloads the counter from the load value. With load value L, pulses therefore repeat every 2^32 - L ticks.
- R9: Control bit 5 enables the prescaler and bits 4:2 hold the prescale value P. When enabled, a tick occurs every 2^(P+1) functional cycles. When disabled, a tick occurs every cycle whatever P holds. Control bits outside 5:2 read 0.
- R10: A trigger write reloads the counter from the load value only when its value differs from the last applied trigger value, whose reset value is 0. Rewriting the same value leaves the pulse timing unchanged.
- R11: A load write does not disturb the running count. The new value first takes effect at the next reload.
- R12: While stopped, `reset_req` stays low and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| func_clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on bus_clk |
| addr | input | 3 | Word address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| autogate_en | output | 1 | Interface clock autogating enable (configuration bit 0) |
| reset_req | output | 1 | Reset request pulse, in the func_clk domain |

## Verification
The bench measures the distance between successive reset pulses in functional cycles, because that interval does not depend on synchronizer latency. A wrong prescaler divisor, an off-by-one at the all-ones rollover, or a reload that ignores the load value all shift that interval.

It breaks the start and stop handshakes with a stray middle word. A design that only remembers the first word would then start or stop when it should not. It rewrites an unchanged trigger value, which a design without the compare would treat as a reload and so stretch the period. It also writes a register twice back to back: a design without the pending-flag gate would overwrite the shadow while the earlier value is still crossing the clock boundary.

// File: rtl/wdog_posted.sv
module wdog_posted #(
  parameter int          DW       = 32,
  parameter int          PTV_W    = 3,
  parameter logic [7:0]  REV_ID   = 8'h21,
  parameter logic [DW-1:0] LOAD_RST = '0
) (
  input  logic          bus_clk,
  input  logic          func_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          autogate_en,
  output logic          reset_req
);

  localparam logic [2:0] A_REV  = 3'd0;
  localparam logic [2:0] A_SYS  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_LOAD = 3'd4;
  localparam logic [2:0] A_TRIG = 3'd5;
  localparam logic [2:0] A_SS   = 3'd6;
  localparam int NP     = 4;
  localparam int P_CTRL = 0;
  localparam int P_LOAD = 1;
  localparam int P_TRIG = 2;
  localparam int P_SS   = 3;
  localparam int DIV_W  = 1 << PTV_W;
  localparam int CW     = PTV_W + 1;
  localparam logic [15:0] K_GO1   = 16'hBBBB;
  localparam logic [15:0] K_GO2   = 16'h4444;
  localparam logic [15:0] K_HALT1 = 16'hAAAA;
  localparam logic [15:0] K_HALT2 = 16'h5555;

  // bus domain
  logic [NP-1:0] pend, req_t, ack_m, ack_s, hit;
  logic [CW-1:0] ctrl_sh;
  logic [DW-1:0] load_sh, trig_sh;
  logic [15:0]   ss_sh;
  logic          sys_r;

  // counter domain
  logic [NP-1:0] rq1, rq2, rq3, apply;
  logic [CW-1:0] ctrl_f;
  logic [DW-1:0] load_f, trig_last, cnt_f;
  logic [DIV_W-1:0] pre;
  logic [DIV_W:0]   div_n;
  logic          arm_go, arm_halt, run_f, rst_req, tick, reload;

  assign hit = {NP{wr_en}} & ~pend &
               {addr == A_SS, addr == A_TRIG, addr == A_LOAD, addr == A_CTRL};

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      req_t   <= '0;
      ack_m   <= '0;
      ack_s   <= '0;
      ctrl_sh <= '0;
      load_sh <= LOAD_RST;
      trig_sh <= '0;
      ss_sh   <= '0;
      sys_r   <= 1'b0;
    end else begin
      ack_m <= rq3;
      ack_s <= ack_m;
      if (wr_en && addr == A_SYS) sys_r <= wdata[0];
      if (hit[P_CTRL]) ctrl_sh <= wdata[PTV_W+2:2];
      if (hit[P_LOAD]) load_sh <= wdata;
      if (hit[P_TRIG]) trig_sh <= wdata;
      if (hit[P_SS])   ss_sh   <= wdata[15:0];
      for (int k = 0; k < NP; k++) begin
        if (hit[k]) begin
          pend[k]  <= 1'b1;
          req_t[k] <= ~req_t[k];
        end else if (pend[k] && ack_s[k] == req_t[k]) begin
          pend[k] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_REV:   rdata = DW'(REV_ID);
      A_SYS:   rdata = DW'(sys_r);
      A_STAT:  rdata = DW'({pend[P_SS], pend[P_TRIG], pend[P_LOAD], 1'b0, pend[P_CTRL]});
      A_CTRL:  rdata = DW'({ctrl_sh, 2'b00});
      A_LOAD:  rdata = load_sh;
      A_TRIG:  rdata = trig_sh;
      A_SS:    rdata = DW'(ss_sh);
      default: rdata = '0;
    endcase
  end

  assign autogate_en = sys_r;

  assign apply  = rq2 ^ rq3;
  assign reload = apply[P_TRIG] && (trig_sh != trig_last);
  assign div_n  = (DIV_W+1)'(2) << ctrl_f[PTV_W-1:0];
  assign tick   = !ctrl_f[PTV_W] || (pre == DIV_W'(div_n - 1'b1));

  always_ff @(posedge func_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1       <= '0;
      rq2       <= '0;
      rq3       <= '0;
      ctrl_f    <= '0;
      load_f    <= LOAD_RST;
      trig_last <= '0;
      cnt_f     <= LOAD_RST;
      pre       <= '0;
      arm_go    <= 1'b0;
      arm_halt  <= 1'b0;
      run_f     <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      rq1     <= req_t;
      rq2     <= rq1;
      rq3     <= rq2;
      rst_req <= 1'b0;
      if (apply[P_CTRL]) ctrl_f    <= ctrl_sh;
      if (apply[P_LOAD]) load_f    <= load_sh;
      if (apply[P_TRIG]) trig_last <= trig_sh;
      if (apply[P_SS]) begin
        arm_go   <= (ss_sh == K_GO1);
        arm_halt <= (ss_sh == K_HALT1);
        if (ss_sh == K_GO2 && arm_go)     run_f <= 1'b1;
        if (ss_sh == K_HALT2 && arm_halt) run_f <= 1'b0;
      end
      if (reload) begin
        cnt_f <= load_f;
        pre   <= '0;
      end else if (!run_f || apply[P_CTRL]) begin
        pre <= '0;
      end else if (tick) begin
        pre <= '0;
        if (&cnt_f) begin
          cnt_f   <= load_f;
          rst_req <= 1'b1;
        end else begin
          cnt_f <= cnt_f + 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign reset_req = rst_req;

  AST_PEND_SET: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == A_LOAD && !pend[P_LOAD]) |=> pend[P_LOAD]);  // R4
  AST_DROP_HOLD: assert property (@(posedge bus_clk) disable iff (!rst_n)
    pend[P_LOAD] |=> $stable(load_sh));  // R5
  AST_GO_SEQ: assert property (@(posedge func_clk) disable iff (!rst_n)
    $rose(run_f) |-> $past(arm_go && apply[P_SS]));  // R6
  AST_HALT_SEQ: assert property (@(posedge func_clk) disable iff (!rst_n)
    $fell(run_f) |-> $past(arm_halt && apply[P_SS]));  // R7
  AST_OVF_ONLY: assert property (@(posedge func_clk) disable iff (!rst_n)
    rst_req |-> $past(&cnt_f));  // R8
  AST_IDLE_QUIET: assert property (@(posedge func_clk) disable iff (!rst_n)
    !run_f |=> !rst_req);  // R12

endmodule

// File: tb/wdog_posted_tb.sv
module wdog_posted_tb;
  localparam logic [7:0] REV = 8'h21;
  localparam logic [2:0] A_REV = 3'd0, A_SYS = 3'd1, A_STAT = 3'd2, A_CTRL = 3'd3,
                         A_LOAD = 3'd4, A_TRIG = 3'd5, A_SS = 3'd6;

  logic bus_clk = 1'b0, func_clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic autogate_en, reset_req;

  wdog_posted #(.DW(32), .PTV_W(3), .REV_ID(REV), .LOAD_RST('0)) u_dut (
    .bus_clk(bus_clk), .func_clk(func_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .autogate_en(autogate_en),
    .reset_req(reset_req));

  always #4  bus_clk  = ~bus_clk;
  always #20 func_clk = ~func_clk;

  int n_chk = 0, n_bad = 0;
  int fcyc = 0, npulse = 0, t_last = 0, t_prev = 0, hi_run = 0, wide = 0;
  logic [31:0] trig_last = 32'h0;

  always @(negedge func_clk) begin
    fcyc++;
    if (reset_req) begin
      hi_run++;
      if (hi_run == 1) begin t_prev = t_last; t_last = fcyc; npulse++; end
      else wide++;
    end else hi_run = 0;
  end

  function automatic int exp_period(int n, bit en, int ptv);
    return en ? n * (2 << ptv) : n;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d);
    @(negedge bus_clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge bus_clk); wr_en = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [31:0] d);
    @(negedge bus_clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      brd(A_STAT, s);
      if (s == 0) break;
    end
  endtask

  task automatic pw(input logic [2:0] a, input logic [31:0] d);
    bwr(a, d); idle();
  endtask

  task automatic fwait(input int n);
    repeat (n) @(posedge func_clk);
  endtask

  task automatic next_iv(output int iv, output bit got);
    int base = npulse;
    int w = 0;
    while (npulse == base && w < 5000) begin @(negedge bus_clk); w++; end
    got = (npulse != base);
    iv = t_last - t_prev;
  endtask

  task automatic start_t(); pw(A_SS, 32'hBBBB); pw(A_SS, 32'h4444); endtask
  task automatic stop_t();  pw(A_SS, 32'hAAAA); pw(A_SS, 32'h5555); endtask
  task automatic new_trig(); trig_last = ~trig_last ^ 32'h1234; pw(A_TRIG, trig_last); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_400_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int iv, base;
    bit got;
    void'($urandom(32'd19));
    #102 rst_n = 1'b1;

    // R1 / R2 reset state
    brd(A_REV, r);  chk(r == {24'd0, REV}, "R2 revision", r, {24'd0, REV});
    brd(A_STAT, r); chk(r == 0, "R1 status after reset", r, 0);
    brd(A_SYS, r);  chk(r == 0 && !autogate_en, "R1 config after reset", r, 0);
    brd(A_CTRL, r); chk(r == 0, "R1 control after reset", r, 0);
    chk(reset_req == 1'b0, "R1 reset_req low", reset_req, 0);
    bwr(A_REV, 32'hFFFF_FFFF);
    brd(A_REV, r);  chk(r == {24'd0, REV}, "R2 write ignored", r, {24'd0, REV});

    // R3
    bwr(A_SYS, 32'h1);
    brd(A_SYS, r); chk(r == 1 && autogate_en, "R3 config set", r, 1);
    bwr(A_SYS, 32'hFFFF_FFFE);
    brd(A_SYS, r); chk(r == 0 && !autogate_en, "R3 config clear", r, 0);

    // R4 / R5 pending flags and dropped writes
    bwr(A_LOAD, 32'hDEAD_0001);
    brd(A_STAT, r); chk(r == 32'h4, "R4 load pending bit 2", r, 4);
    bwr(A_LOAD, 32'hBEEF_0002);
    brd(A_LOAD, r); chk(r == 32'hDEAD_0001, "R5 write dropped while pending", r, 32'hDEAD_0001);
    idle();
    brd(A_STAT, r); chk(r == 0, "R4 flag clears", r, 0);
    bwr(A_CTRL, 32'hFFFF_FFFF);
    brd(A_STAT, r); chk(r == 32'h1, "R4 control pending bit 0", r, 1);
    idle();
    brd(A_CTRL, r); chk(r == 32'h3C, "R9 control field mask", r, 32'h3C);
    bwr(A_SS, 32'h0);
    brd(A_STAT, r); chk(r == 32'h10, "R4 start/stop pending bit 4", r, 32'h10);
    idle();
    pw(A_CTRL, 32'h0);
    pw(A_LOAD, -32'sd20);
    bwr(A_TRIG, 32'h0000_1234); trig_last = 32'h1234;
    brd(A_STAT, r); chk(r == 32'h8, "R4 trigger pending bit 3", r, 8);
    idle();

    // R6 broken start sequence
    pw(A_SS, 32'hBBBB); pw(A_SS, 32'h1234); pw(A_SS, 32'h4444);
    base = npulse; fwait(100);
    chk(npulse == base, "R6 broken start stays idle", npulse - base, 0);
    start_t();
    next_iv(iv, got);
    next_iv(iv, got); chk(got && iv == 20, "R8 period after start", iv, 20);
    chk(got, "R6 proper start runs", got, 1);

    // R10 trigger compare
    fwait(6); pw(A_TRIG, trig_last);
    next_iv(iv, got); chk(got && iv == 20, "R10 same trigger ignored", iv, 20);
    fwait(6); new_trig();
    next_iv(iv, got); chk(got && iv > 20, "R10 new trigger reloads", iv, 21);

    // R11 load takes effect at next reload
    fwait(5); pw(A_LOAD, -32'sd30);
    next_iv(iv, got); chk(got && iv == 20, "R11 running count kept", iv, 20);
    next_iv(iv, got); chk(got && iv == 30, "R11 new load after reload", iv, 30);

    // R7 broken stop, then proper stop (R12)
    pw(A_SS, 32'hAAAA); pw(A_SS, 32'h0); pw(A_SS, 32'h5555);
    next_iv(iv, got); chk(got && iv == 30, "R7 broken stop keeps running", iv, 30);
    stop_t();
    base = npulse; fwait(100);
    chk(npulse == base, "R7 stop halts pulses", npulse - base, 0);
    chk(reset_req == 1'b0, "R12 quiet when stopped", reset_req, 0);

    // R9 directed prescaler cases
    pw(A_CTRL, 32'h24); pw(A_LOAD, -32'sd16); new_trig(); start_t();
    next_iv(iv, got);
    next_iv(iv, got); chk(got && iv == 64, "R9 prescale P=1", iv, 64);
    stop_t();
    pw(A_CTRL, 32'h1C); new_trig(); start_t();
    next_iv(iv, got);
    next_iv(iv, got); chk(got && iv == 16, "R9 prescaler disabled", iv, 16);
    stop_t();

    // R8 / R9 random configurations
    for (int it = 0; it < 6; it++) begin
      int n = 16 + int'($urandom % 25);
      bit en = 1'($urandom % 2);
      int ptv = int'($urandom % 3);
      int p = exp_period(n, en, ptv);
      pw(A_CTRL, {26'd0, en, 3'(ptv), 2'b00});
      pw(A_LOAD, -n);
      brd(A_LOAD, r); chk(r == -n, "R11 load readback", r, -n);
      new_trig(); start_t();
      next_iv(iv, got);
      fwait(int'($urandom % 8));
      next_iv(iv, got); chk(got && iv == p, "R8 random period", iv, p);
      next_iv(iv, got); chk(got && iv == p, "R9 random period repeat", iv, p);
      stop_t();
    end

    chk(wide == 0, "R8 pulse one cycle wide", wide, 0);
    summary();
    $finish;
  end
endmodule